// File: doc/BRIEF.md
# Smart Card T=0 Character Transceiver

This block moves single characters over the one-wire, half-duplex I/O line of a contact smart card running the character-oriented T=0 protocol. Each character on the line is a low start bit, eight data bits sent least significant bit first, and an even-parity bit. The line is open drain: the block only ever pulls it low (`ln_pull`) and reads it back through `ln_in`. Timing comes from a clock enable `tick` that pulses `TICKS` times per elementary time unit (ETU), so each bit lasts `TICKS` ticks and the line is sampled in the middle of each ETU.

Firmware queues outgoing bytes in a transmit FIFO and takes incoming bytes from a receive FIFO. Each FIFO is `DEPTH` entries deep. The direction is chosen explicitly with `rx_mode`. The usual sequence is to set receive mode after the last command byte and to clear it again once the card has answered.

Error handling at the character level is done in hardware. After a bad-parity character is received, the block pulls the line low in the guard period and drops the byte. After the card signals an error on a character the block sent, the block sends the same byte again, up to `MAX_TRY` attempts in all. Each of these two behaviours can be switched off. Single-cycle event pulses report good receptions, parity errors, resends, overruns and failed transmissions.

Top module: `sc_t0_xcvr`

## Requirements
- R1: A transmitted character is one low start bit, then data bits 0 to 7 in that order, then an even-parity bit (the bit equals the XOR of the data), each bit held for `TICKS` ticks. The line is then released.
- R2: The transmit FIFO holds `DEPTH` bytes. `tx_full` is high once it holds `DEPTH` bytes, and a write while full is ignored. Bytes leave in write order.
- R3: Eleven ETUs after the start of its own character, the block samples the line. If the line is low and `retx_en` is 1, the same byte is sent again and `ev_retx` pulses once for each resend.
- R4: When the `MAX_TRY`-th attempt at a byte is also flagged by the card, `ev_txfail` pulses and the byte is discarded. The next queued byte is then sent normally.
- R5: With `retx_en` at 0, a byte flagged by the card is not sent again. `ev_txfail` pulses and `ev_retx` stays low.
- R6: In receive mode, a low level seen while idle starts a character, and each bit is sampled at mid-ETU. A character with good parity is pushed into the receive FIFO and `ev_rx` pulses. `rx_data` shows the oldest byte, and `rx_rd` removes it.
- R7: With `errsig_en` at 1, a bad-parity character makes the block pull the line low from about 10.5 ETU to 12 ETU after its start edge. The byte is dropped, and `ev_perr` pulses.
- R8: With `errsig_en` at 0, a bad-parity character is kept in the receive FIFO, the line is not pulled, and `ev_perr` pulses without `ev_rx`.
- R9: A character that completes while the receive FIFO is full is dropped, and `ev_ovr` pulses. The stored bytes are unaffected.
- R10: The direction is taken from `rx_mode` only between characters. In receive mode, queued transmit bytes wait. In transmit mode, characters arriving on the line are ignored.
- R11: After reset the line is released, both FIFOs are empty and no event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable, `TICKS` pulses per ETU |
| ln_in | input | 1 | Level of the card I/O line |
| ln_pull | output | 1 | 1 pulls the I/O line low |
| rx_mode | input | 1 | 1 selects receive, 0 selects transmit |
| errsig_en | input | 1 | Enables the error signal and dropping of bad-parity bytes |
| retx_en | input | 1 | Enables automatic resending |
| tx_wr | input | 1 | Writes `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd | input | 1 | Removes the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive FIFO empty |
| ev_rx | output | 1 | Pulse: good byte stored |
| ev_perr | output | 1 | Pulse: received parity error |
| ev_retx | output | 1 | Pulse: byte being resent |
| ev_ovr | output | 1 | Pulse: receive overrun |
| ev_txfail | output | 1 | Pulse: byte abandoned after a card error |

## Verification
The bench uses `TICKS` = 4, `DEPTH` = 2 and `MAX_TRY` = 4, with `tick` pulsing on every second clock so that the enable path is exercised. With a depth of two, a full transmit queue and a receive overrun are reached with only three bytes. With four tries, the full resend sequence and its abandonment fit in four characters. A behavioural card model in the bench decodes the block's characters and sends its own, optionally with bad parity or an error signal. Its queues of expected bytes and event counts are compared with the ports.

// File: rtl/sc_t0_xcvr.sv
module sc_t0_xcvr #(
  parameter int TICKS   = 4,
  parameter int DEPTH   = 2,
  parameter int MAX_TRY = 4
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ln_in,
  output logic       ln_pull,
  input  logic       rx_mode,
  input  logic       errsig_en,
  input  logic       retx_en,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  output logic       tx_full,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       rx_empty,
  output logic       ev_rx,
  output logic       ev_perr,
  output logic       ev_retx,
  output logic       ev_ovr,
  output logic       ev_txfail
);
  localparam int PW   = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(MAX_TRY) + 1;
  localparam int HALF = TICKS / 2;
  localparam logic [AW:0] QFULL = (AW+1)'(DEPTH);

  typedef enum logic [1:0] {IDLE, XMIT, RECV} st_t;
  st_t st;

  logic [7:0]    txq [DEPTH];
  logic [7:0]    rxq [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]   tx_cnt, rx_cnt;
  logic [PW-1:0] ph;
  logic [3:0]    bn;
  logic [7:0]    sh;
  logic          txerr, perr, errdrv;
  logic [CW-1:0] tries;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  wire ph_last  = tick && ph == PW'(TICKS-1);
  wire mid      = tick && ph == PW'(HALF);
  wire tx_end   = st == XMIT && ph_last && bn == (txerr ? 4'd12 : 4'd11);
  wire tx_again = tx_end && txerr && retx_en && tries != CW'(MAX_TRY-1);
  wire rx_bad   = ln_in != ^sh;
  wire rx_keep  = st == RECV && mid && bn == 4'd9 && (!rx_bad || !errsig_en);
  wire rx_full  = rx_cnt == QFULL;
  wire tx_push  = tx_wr && !tx_full;
  wire tx_pop   = tx_end && !tx_again;
  wire rx_push  = rx_keep && !rx_full;
  wire rx_pop   = rx_rd && !rx_empty;

  assign tx_full  = tx_cnt == QFULL;
  assign rx_empty = rx_cnt == '0;
  assign rx_data  = rxq[rx_rp];

  always_ff @(posedge clk) begin
    if (tx_push) txq[tx_wp] <= tx_data;
    if (rx_push) rxq[rx_wp] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= bump(tx_wp);
      if (tx_pop)  tx_rp <= bump(tx_rp);
      if (rx_push) rx_wp <= bump(rx_wp);
      if (rx_pop)  rx_rp <= bump(rx_rp);
      tx_cnt <= tx_cnt + (AW+1)'(tx_push) - (AW+1)'(tx_pop);
      rx_cnt <= rx_cnt + (AW+1)'(rx_push) - (AW+1)'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ph <= '0; bn <= '0; sh <= '0;
      txerr <= 1'b0; perr <= 1'b0; errdrv <= 1'b0; tries <= '0;
      ev_rx <= 1'b0; ev_perr <= 1'b0; ev_retx <= 1'b0;
      ev_ovr <= 1'b0; ev_txfail <= 1'b0;
    end else begin
      ev_rx <= 1'b0; ev_perr <= 1'b0; ev_retx <= 1'b0;
      ev_ovr <= 1'b0; ev_txfail <= 1'b0;
      if (tick) begin
        if (st != IDLE) begin
          ph <= ph_last ? '0 : ph + 1'b1;
          if (ph_last) bn <= bn + 4'd1;
        end
        case (st)
          IDLE: begin
            if (rx_mode) begin
              if (!ln_in) begin
                st <= RECV; ph <= PW'(1); bn <= '0; perr <= 1'b0;
              end
            end else if (tx_cnt != '0) begin
              st <= XMIT; ph <= '0; bn <= '0; sh <= txq[tx_rp]; txerr <= 1'b0;
            end
          end
          XMIT: begin
            if (bn == 4'd11 && ph == '0) txerr <= !ln_in;
            if (tx_end) begin
              if (tx_again) begin
                tries <= tries + CW'(1); ev_retx <= 1'b1;
                bn <= '0; txerr <= 1'b0;
              end else begin
                st <= IDLE; tries <= '0;
                if (txerr) ev_txfail <= 1'b1;
              end
            end
          end
          RECV: begin
            if (mid) begin
              if (bn == 4'd0 && ln_in) st <= IDLE;
              if (bn >= 4'd1 && bn <= 4'd8) sh <= {ln_in, sh[7:1]};
              if (bn == 4'd9) begin
                perr    <= rx_bad && errsig_en;
                ev_perr <= rx_bad;
                ev_rx   <= !rx_bad && !rx_full;
                ev_ovr  <= rx_keep && rx_full;
              end
              if (bn == 4'd10) errdrv <= perr;
            end
            if (ph_last && bn == 4'd11) begin
              st <= IDLE; errdrv <= 1'b0;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_comb begin
    ln_pull = 1'b0;
    case (st)
      XMIT: begin
        if (bn == 4'd0)       ln_pull = 1'b1;
        else if (bn <= 4'd8)  ln_pull = !sh[3'(bn - 4'd1)];
        else if (bn == 4'd9)  ln_pull = !(^sh);
      end
      RECV:    ln_pull = errdrv;
      default: ln_pull = 1'b0;
    endcase
  end

  // R6
  rx_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx |-> !rx_empty);

  // R9
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovr |-> $past(rx_cnt) == QFULL);

  // R5
  retx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retx |-> $past(retx_en));

  // R7
  perr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_perr && $past(errsig_en) && !$past(rx_rd)) |-> rx_cnt == $past(rx_cnt));

  // R2
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= QFULL && rx_cnt <= QFULL);

  // R8
  perr_norx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_perr && ev_rx));
endmodule

// File: tb/tb_sc_t0_xcvr.sv
module tb_sc_t0_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int ETU = 8;

  logic clk = 0, rst_n = 0, tick = 0;
  logic rx_mode = 0, errsig_en = 1, retx_en = 1, tx_wr = 0, rx_rd = 0;
  logic [7:0] tx_data = 0;
  logic ln_pull, tx_full, rx_empty, ev_rx, ev_perr, ev_retx, ev_ovr, ev_txfail;
  logic [7:0] rx_data;
  logic card_low = 0, card_busy = 0;
  int card_errs = 0;
  wire ln = !(ln_pull || card_low);

  int checks = 0, fails = 0;
  int n_rx = 0, n_perr = 0, n_retx = 0, n_ovr = 0, n_fail = 0, mon_bad = 0;
  logic [8:0] got [$];

  sc_t0_xcvr #(.TICKS(4), .DEPTH(2), .MAX_TRY(4)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ln_in(ln), .ln_pull(ln_pull),
    .rx_mode(rx_mode), .errsig_en(errsig_en), .retx_en(retx_en),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_empty(rx_empty),
    .ev_rx(ev_rx), .ev_perr(ev_perr), .ev_retx(ev_retx),
    .ev_ovr(ev_ovr), .ev_txfail(ev_txfail));

  always #(CLK_PERIOD/2) clk = !clk;
  always @(posedge clk) tick <= rst_n ? !tick : 1'b0;

  always @(posedge clk) begin
    n_rx   <= n_rx + int'(ev_rx);
    n_perr <= n_perr + int'(ev_perr);
    n_retx <= n_retx + int'(ev_retx);
    n_ovr  <= n_ovr + int'(ev_ovr);
    n_fail <= n_fail + int'(ev_txfail);
  end

  // per-clock monitor: an errored byte never also counts as a good one (R8)
  always @(negedge clk) if (rst_n && ev_rx && ev_perr) mon_bad++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // card receiver: decodes characters driven by the block
  initial begin
    logic [9:0] f;
    forever begin
      @(negedge clk);
      if (rst_n && !card_busy && !ln) begin
        repeat (4) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
          f[k] = ln;
          if (k < 9) repeat (ETU) @(negedge clk);
        end
        got.push_back({f[0] == 1'b0 && f[9] == ^f[8:1], f[8:1]});
        if (card_errs > 0) begin
          card_errs--;
          repeat (8) @(negedge clk);
          card_low = 1;
          repeat (12) @(negedge clk);
          card_low = 0;
        end
        while (!ln) @(negedge clk);
      end
    end
  end

  task automatic card_send(input logic [7:0] b, input bit badpar,
                           output bit saw_err, output bit rel_ok);
    logic [9:0] f;
    f = {(^b) ^ badpar, b, 1'b0};
    card_busy = 1;
    for (int i = 0; i < 10; i++) begin
      card_low = !f[i];
      repeat (ETU) @(negedge clk);
    end
    card_low = 0;
    repeat (10) @(negedge clk);
    saw_err = !ln;
    repeat (10) @(negedge clk);
    rel_ok = ln;
    repeat (14) @(negedge clk);
    card_busy = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); tx_wr = 1; tx_data = d;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic pop();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic wait_got(input int n);
    int t = 0;
    while (got.size() < n && t < 3000) begin @(negedge clk); t++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit se, ro;
    int b_rx, b_perr, b_retx, b_ovr, b_fail, g0;
    repeat (5) @(negedge clk);
    chk(ln_pull == 0 && tx_full == 0 && rx_empty == 1, "R11 reset outputs",
        {ln_pull, tx_full, rx_empty}, 3'b001);
    chk({ev_rx, ev_perr, ev_retx, ev_ovr, ev_txfail} == 0, "R11 events idle",
        {ev_rx, ev_perr, ev_retx, ev_ovr, ev_txfail}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 single byte
    wr(8'hA5); wait_got(1); repeat (40) @(negedge clk);
    chk(got.size() == 1 && got[0] == 9'h1A5, "R1 frame A5", got[0], 9'h1A5);

    // R2 queue depth
    g0 = got.size();
    @(negedge clk); tx_wr = 1; tx_data = 8'h11;
    @(negedge clk); tx_data = 8'h22;
    @(negedge clk);
    chk(tx_full == 1, "R2 full after two writes", tx_full, 1);
    tx_data = 8'h33;
    @(negedge clk); tx_wr = 0;
    wait_got(g0 + 2); repeat (400) @(negedge clk);
    chk(got.size() == g0 + 2, "R2 third write ignored", got.size() - g0, 2);
    chk(got[g0] == 9'h111 && got[g0+1] == 9'h122, "R2 order",
        {got[g0][7:0], got[g0+1][7:0]}, 16'h1122);
    chk(tx_full == 0, "R2 drained", tx_full, 0);

    // R3 one card error, resend
    g0 = got.size(); b_retx = n_retx; b_fail = n_fail;
    card_errs = 1; wr(8'h5A); wait_got(g0 + 2); repeat (60) @(negedge clk);
    chk(got.size() == g0 + 2 && got[g0] == 9'h15A && got[g0+1] == 9'h15A,
        "R3 byte resent", got.size() - g0, 2);
    chk(n_retx - b_retx == 1 && n_fail == b_fail, "R3 one retx pulse", n_retx - b_retx, 1);

    // R4 exhausted tries then next byte
    g0 = got.size(); b_retx = n_retx; b_fail = n_fail;
    card_errs = 4; wr(8'hC3); wr(8'h7E); wait_got(g0 + 5); repeat (60) @(negedge clk);
    chk(got.size() == g0 + 5 && got[g0+3] == 9'h1C3 && got[g0+4] == 9'h17E,
        "R4 four attempts then next", got.size() - g0, 5);
    chk(n_retx - b_retx == 3, "R4 retx count", n_retx - b_retx, 3);
    chk(n_fail - b_fail == 1, "R4 txfail", n_fail - b_fail, 1);

    // R5 resend disabled
    retx_en = 0; g0 = got.size(); b_retx = n_retx; b_fail = n_fail;
    card_errs = 1; wr(8'h99); wr(8'h66); wait_got(g0 + 2); repeat (200) @(negedge clk);
    chk(got.size() == g0 + 2 && got[g0] == 9'h199 && got[g0+1] == 9'h166,
        "R5 no resend", got.size() - g0, 2);
    chk(n_retx == b_retx && n_fail - b_fail == 1, "R5 txfail only", n_fail - b_fail, 1);
    retx_en = 1;

    // R10 line ignored in transmit mode
    b_rx = n_rx;
    card_send(8'h42, 0, se, ro);
    chk(n_rx == b_rx && rx_empty == 1, "R10 tx mode ignores line", n_rx - b_rx, 0);

    // R10 queued byte waits in receive mode
    rx_mode = 1; g0 = got.size();
    wr(8'h77); repeat (200) @(negedge clk);
    chk(got.size() == g0 && ln_pull == 0, "R10 rx mode holds tx", got.size() - g0, 0);

    // R6 good reception
    b_rx = n_rx;
    card_send(8'h3C, 0, se, ro);
    chk(se == 0 && n_rx - b_rx == 1, "R6 good byte event", n_rx - b_rx, 1);
    chk(rx_empty == 0 && rx_data == 8'h3C, "R6 data", rx_data, 8'h3C);
    pop();
    chk(rx_empty == 1, "R6 pop", rx_empty, 1);

    // R7 parity error with error signal
    b_rx = n_rx; b_perr = n_perr;
    card_send(8'h81, 1, se, ro);
    chk(se == 1 && ro == 1, "R7 error signal on line", {se, ro}, 2'b11);
    chk(n_perr - b_perr == 1 && n_rx == b_rx && rx_empty == 1, "R7 dropped",
        {n_perr - b_perr, rx_empty}, 2'b11);

    // R8 parity error kept
    errsig_en = 0; b_rx = n_rx; b_perr = n_perr;
    card_send(8'h81, 1, se, ro);
    chk(se == 0, "R8 no error signal", se, 0);
    chk(n_perr - b_perr == 1 && n_rx == b_rx, "R8 perr without rx", n_rx - b_rx, 0);
    chk(rx_empty == 0 && rx_data == 8'h81, "R8 byte kept", rx_data, 8'h81);
    pop(); errsig_en = 1;

    // R9 overrun
    b_rx = n_rx; b_ovr = n_ovr;
    card_send(8'h01, 0, se, ro);
    card_send(8'h02, 0, se, ro);
    card_send(8'h03, 0, se, ro);
    chk(n_rx - b_rx == 2 && n_ovr - b_ovr == 1, "R9 overrun event", n_ovr - b_ovr, 1);
    chk(rx_data == 8'h01, "R9 first kept", rx_data, 8'h01);
    pop();
    chk(rx_data == 8'h02, "R9 second kept", rx_data, 8'h02);
    pop();
    chk(rx_empty == 1, "R9 third dropped", rx_empty, 1);

    // R10 back to transmit sends held byte
    rx_mode = 0; wait_got(g0 + 1); repeat (40) @(negedge clk);
    chk(got.size() == g0 + 1 && got[g0] == 9'h177, "R10 held byte sent", got[g0], 9'h177);

    chk(mon_bad == 0, "R8 per-clock monitor", mon_bad, 0);
    summary();
  end
endmodule